// File: doc/BRIEF.md
# Four-Phase Byte ALU Instruction Executor

This block runs one 16-bit instruction word at a time against an 8-bit working register, a five-bit status set (negative, overflow, carry, digit carry, zero) and an internal banked byte store. Two operations are recognised. The first adds the working register, a byte from the store and the carry flag. The second ANDs an 8-bit literal into the working register. Every other word is accepted and retired without effect.

A pulse on `start` while the block is idle captures the instruction word and the bank number. The instruction then passes through four clock cycles: decode, operand fetch, compute, and commit. The commit cycle raises `done`. When the destination is the store, the same cycle raises `mem_we` and presents the target address and the byte being written. The surrounding logic can follow all memory traffic through that strobe.

Top module: `byte_alu_exec`

## Requirements
- R1: A word whose bits [15:10] equal 6'b001000 is an add. Its result is (working register + store byte + carry flag) mod 256.
- R2: For the add, bit 9 picks the destination. With 0 the result goes to the working register and the store is untouched. With 1 it is written back to the store byte and the working register is unchanged.
- R3: For the add, bits [7:0] are a byte offset f and bit 8 picks the address. With 1 the address is {bank_sel, f}. With 0, bank_sel is ignored: f below 0x80 addresses {0, f} and f at or above 0x80 addresses {all ones, f}.
- R4: After an add, N is result bit 7 and Z is set when the result is zero. C is the carry out of bit 7 and DC is the carry out of bit 3. OV is set when the true signed sum of the two operands and the carry lies outside -128..127.
- R5: A word whose bits [15:8] equal 8'h0B ANDs bits [7:0] into the working register, then sets N to bit 7 of the result and Z when the result is zero.
- R6: The AND leaves OV, C and DC at their previous values.
- R7: After `start` is taken at a clock edge, `busy` is high for exactly four cycles. `done` is high in the fourth of them only. Results are visible in the cycle after `done`.
- R8: `start` is ignored while `busy` is high.
- R9: Any other instruction word changes neither the working register, nor the flags, nor the store, and still completes with `done`.
- R10: Reset sets the working register to 0xFF, clears all five flags and leaves the block idle. It fills each store byte at address A with (A mod 256) XOR (A / 256).
- R11: `mem_we` is high only in the commit cycle of an add whose destination is the store. In that cycle `mem_addr` and `mem_wdata` carry the address and the byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, taken while idle |
| instr | input | 16 | Instruction word, captured with start |
| bank_sel | input | BANK_W | Bank number, captured with start |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | Commit cycle of the instruction |
| wreg | output | 8 | Working register |
| flag_n | output | 1 | Negative flag |
| flag_ov | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry flag |
| flag_dc | output | 1 | Digit carry flag (bit 3) |
| flag_z | output | 1 | Zero flag |
| mem_we | output | 1 | Store write in this cycle |
| mem_addr | output | BANK_W+8 | Store address of the current instruction |
| mem_wdata | output | 8 | Byte written to the store |

## Verification
The properties assume that `start` and `instr` change only between edges and that reset is held for at least one edge before the first launch. The bench drives every input on the falling clock and never launches while a previous instruction is in flight, except for one deliberate stray pulse during the fetch cycle. That pulse must be ignored. With the stimulus kept in this form, the handshake properties can rely on each `start` either launching a new instruction or being dropped.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DECODE,
      PH_FETCH,
      PH_EXEC,
      PH_COMMIT
   } phase_t;

   typedef enum logic [1:0] {
      OP_NOP,
      OP_ADDC,
      OP_ANDL
   } op_t;

   typedef struct packed {
      logic n;
      logic ov;
      logic c;
      logic dc;
      logic z;
   } flags_t;

   localparam logic [5:0] ADDC_CODE = 6'b001000;
   localparam logic [7:0] ANDL_CODE = 8'h0B;

endpackage

// File: rtl/byte_alu_decode.sv
module byte_alu_decode
   import byte_alu_pkg::*;
#(
   parameter int          BANK_W    = 4,
   parameter logic [7:0]  ACC_SPLIT = 8'h80
) (
   input  logic [15:0]         instr,
   input  logic [BANK_W-1:0]   bank,
   output op_t                 op,
   output logic                to_store,
   output logic [BANK_W+7:0]   addr
);

   logic [7:0] offs;
   logic       banked;

   assign offs     = instr[7:0];
   assign banked   = instr[8];
   assign to_store = instr[9];

   always_comb begin
      if (instr[15:10] == ADDC_CODE)
         op = OP_ADDC;
      else if (instr[15:8] == ANDL_CODE)
         op = OP_ANDL;
      else
         op = OP_NOP;
   end

   always_comb begin
      if (banked)
         addr = {bank, offs};
      else if (offs < ACC_SPLIT)
         addr = {{BANK_W{1'b0}}, offs};
      else
         addr = {{BANK_W{1'b1}}, offs};
   end

endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
   import byte_alu_pkg::*;
#(
   parameter bit RIPPLE = 1'b1
) (
   input  op_t        op,
   input  logic [7:0] acc,
   input  logic [7:0] opnd,
   input  flags_t     fl_in,
   output logic [7:0] res,
   output flags_t     fl_out
);

   logic [7:0] sum;
   logic       c_hi;
   logic       c_lo;
   logic       v_out;

   generate
      if (RIPPLE) begin : g_ripple
         logic [8:0] cy;
         assign cy[0] = fl_in.c;
         for (genvar i = 0; i < 8; i++) begin : g_bit
            assign sum[i]  = acc[i] ^ opnd[i] ^ cy[i];
            assign cy[i+1] = (acc[i] & opnd[i]) | (cy[i] & (acc[i] ^ opnd[i]));
         end
         assign c_hi  = cy[8];
         assign c_lo  = cy[4];
         assign v_out = cy[8] ^ cy[7];
      end else begin : g_nibble
         logic [4:0] lo;
         logic [4:0] hi;
         assign lo    = {1'b0, acc[3:0]} + {1'b0, opnd[3:0]} + {4'b0, fl_in.c};
         assign hi    = {1'b0, acc[7:4]} + {1'b0, opnd[7:4]} + {4'b0, lo[4]};
         assign sum   = {hi[3:0], lo[3:0]};
         assign c_hi  = hi[4];
         assign c_lo  = lo[4];
         assign v_out = (acc[7] ~^ opnd[7]) & (hi[3] ^ acc[7]);
      end
   endgenerate

   always_comb begin
      fl_out = fl_in;
      res    = acc;
      case (op)
         OP_ADDC: begin
            res       = sum;
            fl_out.n  = sum[7];
            fl_out.z  = (sum == 8'h00);
            fl_out.c  = c_hi;
            fl_out.dc = c_lo;
            fl_out.ov = v_out;
         end
         OP_ANDL: begin
            res       = acc & opnd;
            fl_out.n  = res[7];
            fl_out.z  = (res == 8'h00);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/byte_alu_store.sv
module byte_alu_store #(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);

   localparam int DEPTH = 1 << AW;

   logic [7:0] cells [DEPTH];

   function automatic logic [7:0] seed(input int idx);
      return 8'(idx) ^ 8'(idx >> 8);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            cells[i] <= seed(i);
      end else if (we) begin
         cells[addr] <= wdata;
      end
   end

   assign rdata = cells[addr];

endmodule

// File: rtl/byte_alu_exec.sv
module byte_alu_exec
   import byte_alu_pkg::*;
#(
   parameter int          BANK_W    = 4,
   parameter logic [7:0]  ACC_SPLIT = 8'h80,
   parameter logic [7:0]  W_INIT    = 8'hFF,
   parameter bit          RIPPLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [15:0]       instr,
   input  logic [BANK_W-1:0] bank_sel,
   output logic              busy,
   output logic              done,
   output logic [7:0]        wreg,
   output logic              flag_n,
   output logic              flag_ov,
   output logic              flag_c,
   output logic              flag_dc,
   output logic              flag_z,
   output logic              mem_we,
   output logic [BANK_W+7:0] mem_addr,
   output logic [7:0]        mem_wdata
);

   localparam int AW = BANK_W + 8;

   generate
      if (BANK_W < 1 || BANK_W > 8) begin : g_bad_bank
         $error("byte_alu_exec: BANK_W must lie in 1..8");
      end
      if (ACC_SPLIT == 8'h00) begin : g_bad_split
         $error("byte_alu_exec: ACC_SPLIT must be nonzero");
      end
   endgenerate

   phase_t            phase;
   logic [15:0]       ir;
   logic [BANK_W-1:0] bank_q;
   op_t               op_q;
   logic              dest_store;
   logic [AW-1:0]     addr_q;
   logic [7:0]        opnd_q;
   logic [7:0]        res_q;
   flags_t            flags_q;
   flags_t            flags_nx;
   logic [7:0]        w_q;

   op_t               dec_op;
   logic              dec_to_store;
   logic [AW-1:0]     dec_addr;
   logic [7:0]        rd_data;
   logic [7:0]        core_res;
   flags_t            core_flags;

   byte_alu_decode #(
      .BANK_W    (BANK_W),
      .ACC_SPLIT (ACC_SPLIT)
   ) i_decode (
      .instr    (ir),
      .bank     (bank_q),
      .op       (dec_op),
      .to_store (dec_to_store),
      .addr     (dec_addr)
   );

   byte_alu_core #(
      .RIPPLE (RIPPLE)
   ) i_core (
      .op     (op_q),
      .acc    (w_q),
      .opnd   (opnd_q),
      .fl_in  (flags_q),
      .res    (core_res),
      .fl_out (core_flags)
   );

   byte_alu_store #(
      .AW (AW)
   ) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .addr  (addr_q),
      .wdata (res_q),
      .rdata (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         ir         <= '0;
         bank_q     <= '0;
         op_q       <= OP_NOP;
         dest_store <= 1'b0;
         addr_q     <= '0;
         opnd_q     <= '0;
         res_q      <= '0;
         flags_nx   <= '0;
         flags_q    <= '0;
         w_q        <= W_INIT;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  ir     <= instr;
                  bank_q <= bank_sel;
                  phase  <= PH_DECODE;
               end
            end
            PH_DECODE: begin
               op_q       <= dec_op;
               dest_store <= dec_to_store;
               addr_q     <= dec_addr;
               phase      <= PH_FETCH;
            end
            PH_FETCH: begin
               opnd_q <= (op_q == OP_ADDC) ? rd_data : ir[7:0];
               phase  <= PH_EXEC;
            end
            PH_EXEC: begin
               res_q    <= core_res;
               flags_nx <= core_flags;
               phase    <= PH_COMMIT;
            end
            PH_COMMIT: begin
               if (op_q == OP_ANDL || (op_q == OP_ADDC && !dest_store))
                  w_q <= res_q;
               if (op_q != OP_NOP)
                  flags_q <= flags_nx;
               phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy      = (phase != PH_IDLE);
   assign done      = (phase == PH_COMMIT);
   assign mem_we    = done && (op_q == OP_ADDC) && dest_store;
   assign mem_addr  = addr_q;
   assign mem_wdata = res_q;
   assign wreg      = w_q;
   assign flag_n    = flags_q.n;
   assign flag_ov   = flags_q.ov;
   assign flag_c    = flags_q.c;
   assign flag_dc   = flags_q.dc;
   assign flag_z    = flags_q.z;

endmodule

// File: rtl/byte_alu_exec_chk.sv
module byte_alu_exec_chk
   import byte_alu_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       mem_we,
   input logic [7:0] wreg,
   input logic       flag_n,
   input logic       flag_ov,
   input logic       flag_c,
   input logic       flag_dc,
   input logic       flag_z,
   input op_t        op_q
);

   a_r7_done_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r7_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   a_r7_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));

   a_r8_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   a_r11_write_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> done);

   a_r2_wreg_only_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(wreg));

   a_r6_and_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_ANDL) |=> ($stable(flag_ov) && $stable(flag_c) && $stable(flag_dc)));

   a_r9_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_NOP) |=> ($stable(wreg) && $stable(flag_n) && $stable(flag_ov)
                                    && $stable(flag_c) && $stable(flag_dc) && $stable(flag_z)));

   a_r9_nop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_NOP) |-> !mem_we);

endmodule

bind byte_alu_exec byte_alu_exec_chk i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .mem_we  (mem_we),
   .wreg    (wreg),
   .flag_n  (flag_n),
   .flag_ov (flag_ov),
   .flag_c  (flag_c),
   .flag_dc (flag_dc),
   .flag_z  (flag_z),
   .op_q    (op_q)
);

// File: tb/test_byte_alu_exec.sv
module test_byte_alu_exec;

   localparam int CLK_PERIOD = 10;
   localparam int BANK_W     = 4;
   localparam int AW         = BANK_W + 8;
   localparam int DEPTH      = 1 << AW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [15:0]       instr = '0;
   logic [BANK_W-1:0] bank_sel = '0;
   logic              busy, done;
   logic [7:0]        wreg;
   logic              flag_n, flag_ov, flag_c, flag_dc, flag_z;
   logic              mem_we;
   logic [AW-1:0]     mem_addr;
   logic [7:0]        mem_wdata;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int m_mem [DEPTH];
   int m_w, m_n, m_ov, m_c, m_dc, m_z;

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_alu_exec i_byte_alu_exec (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .instr     (instr),
      .bank_sel  (bank_sel),
      .busy      (busy),
      .done      (done),
      .wreg      (wreg),
      .flag_n    (flag_n),
      .flag_ov   (flag_ov),
      .flag_c    (flag_c),
      .flag_dc   (flag_dc),
      .flag_z    (flag_z),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_handshake(input string req, input int eb, input int ed, input int ewe);
      chk(req, "busy", int'(busy), eb);
      chk(req, "done", int'(done), ed);
      chk(req, "mem_we", int'(mem_we), ewe);
   endtask

   task automatic chk_state(input string req);
      chk(req, "wreg", int'(wreg), m_w);
      chk(req, "N", int'(flag_n), m_n);
      chk(req, "OV", int'(flag_ov), m_ov);
      chk(req, "C", int'(flag_c), m_c);
      chk(req, "DC", int'(flag_dc), m_dc);
      chk(req, "Z", int'(flag_z), m_z);
   endtask

   task automatic run(input int ins, input int bsr, input bit noise, input string req);
      int kind, f, addr, v, r, s, sw, sv, wr_en;
      f = ins & 255;
      if ((ins >> 10) == 8) kind = 1;
      else if ((ins >> 8) == 11) kind = 2;
      else kind = 0;
      if ((ins >> 8) % 2 == 1) addr = bsr * 256 + f;
      else if (f < 128) addr = f;
      else addr = (DEPTH - 256) + f;
      wr_en = (kind == 1 && ((ins >> 9) % 2 == 1)) ? 1 : 0;
      r = m_w;
      if (kind == 1) begin
         v  = m_mem[addr];
         s  = m_w + v + m_c;
         r  = s % 256;
         sw = (m_w >= 128) ? m_w - 256 : m_w;
         sv = (v >= 128) ? v - 256 : v;
         m_dc = ((m_w % 16) + (v % 16) + m_c) >= 16 ? 1 : 0;
         m_ov = ((sw + sv + m_c) > 127 || (sw + sv + m_c) < -128) ? 1 : 0;
         m_c  = (s >= 256) ? 1 : 0;
         m_n  = (r >= 128) ? 1 : 0;
         m_z  = (r == 0) ? 1 : 0;
      end else if (kind == 2) begin
         r   = m_w & f;
         m_n = (r >= 128) ? 1 : 0;
         m_z = (r == 0) ? 1 : 0;
      end

      @(negedge clk);
      instr = ins[15:0]; bank_sel = bsr[BANK_W-1:0]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk_handshake({req, " R7 decode"}, 1, 0, 0);
      if (noise) begin
         instr = 16'h0B00; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0; instr = ins[15:0];
      chk_handshake({req, " R7 fetch"}, 1, 0, 0);
      @(negedge clk);
      chk_handshake({req, " R7 exec"}, 1, 0, 0);
      @(negedge clk);
      chk_handshake({req, " R7 commit"}, 1, 1, wr_en);
      if (wr_en == 1) begin
         chk({req, " R11"}, "mem_addr", int'(mem_addr), addr);
         chk({req, " R11"}, "mem_wdata", int'(mem_wdata), r);
         m_mem[addr] = r;
      end else if (kind != 0) begin
         m_w = r;
      end
      @(negedge clk);
      chk_handshake({req, " R7 idle"}, 0, 0, 0);
      chk_state(req);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = (i % 256) ^ (i / 256);
      m_w = 255; m_n = 0; m_ov = 0; m_c = 0; m_dc = 0; m_z = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_handshake("R10 reset", 0, 0, 0);
      chk_state("R10 reset");

      run(16'h2205, 0,  0, "R2 R11");   // 0xFF+0x05 -> store, C=1
      run(16'h0B4D, 0,  0, "R5");       // W=0x4D, carry kept
      run(16'h2002, 0,  0, "R1");       // 1+0x4D+0x02 = 0x50, C=0
      run(16'h0BA3, 0,  0, "R5");       // 0x50 & 0xA3 = 0, Z=1
      run(16'h21A3, 0,  0, "R3 R10");   // banked read of seeded 0x0A3
      run(16'h0B5F, 0,  0, "R5");       // 0xA3 & 0x5F = 0x03
      run(16'h2310, 7,  0, "R3 R11");   // banked write to 0x710
      run(16'h2110, 7,  0, "R2");       // read back written byte
      run(16'h0B00, 0,  0, "R5");
      run(16'h2070, 10, 0, "R3");       // access bank, bank_sel ignored
      run(16'h2070, 3,  0, "R4");       // 0x70+0x70 signed overflow
      run(16'h0BF0, 0,  0, "R6");       // OV/C/DC kept
      run(16'h20FF, 0,  0, "R4");       // upper access region 0xFFF
      run(16'h2080, 0,  0, "R4");       // 0xF80, carry in, OV and DC
      run(16'h0B3C, 0,  1, "R8");       // stray start during fetch
      run(16'hFFFF, 0,  0, "R9");
      run(16'h0C55, 0,  0, "R9");
      run(16'h2C00, 0,  0, "R9");
      run(16'h2380, 15, 0, "R3 R11");   // banked write to 0xF80
      run(16'h2080, 2,  0, "R1");       // access read sees the write

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule